// File: doc/BRIEF.md
# Page Frame Replacement Selector

This block decides which physical frame receives the next page brought in on a page fault. It tracks a fixed number of frames (parameter `NUM_FRAMES`, default 3) in one ordered queue of frame indices. The head of the queue is the next victim and the tail is the most recent entry. While some frame has never been filled, the block points at that free frame, and no resident page is evicted.

A single policy input selects the replacement rule. Under first-in-first-out the queue keeps load order, and hit notifications have no effect. Under least-recently-used every hit on a resident frame moves that frame to the tail, so the head is always the frame that has gone unreferenced longest. The system software reads `victim_frame` when a fault occurs, loads the page into that frame, and pulses `fill_valid`. It pulses `hit_valid` with the frame index whenever a reference lands in a resident page.

Top module: `rs_frame_replacer`

## Requirements
- R1: After reset, all frames are free: `free_avail` is 1 and `victim_frame` is 0.
- R2: While `free_avail` is 1, `victim_frame` names the lowest-indexed frame that has never been filled. A fill occupies that frame without evicting anything, so frames fill in the order 0, 1, ..., NUM_FRAMES-1.
- R3: Once NUM_FRAMES fills have occurred, `free_avail` is 0 and stays 0 until reset.
- R4: With `policy_lru` = 0 and all frames occupied, `victim_frame` is the frame whose current page was loaded earliest.
- R5: A fill while no frame is free evicts the head frame. In the same clock edge that frame moves to the tail and the next entry becomes the head, so `victim_frame` shows the new head from the following cycle.
- R6: With `policy_lru` = 0, a hit leaves `victim_frame` and `free_avail` unchanged.
- R7: With `policy_lru` = 1, a hit on a resident frame moves it to the tail, so `victim_frame` is the least recently referenced resident frame.
- R8: If `hit_valid` and `fill_valid` are both 1 in one cycle, the fill is applied and the hit is discarded.
- R9: With 3 frames and references to pages 6 8 3 8 6 0 3 6 3 5 3 6, there are 7 faults under the first-in-first-out rule and 6 faults under the least-recently-used rule. The evicted pages are 6, 8, 3, 0 under the first rule and 3, 8, 0 under the second.
- R10: A hit naming a frame that has not been filled yet is ignored.
- R11: Outputs come from registered state only. A notification affects `free_avail` and `victim_frame` only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_lru | input | 1 | 0 = first-in-first-out, 1 = least-recently-used |
| hit_valid | input | 1 | A reference landed in resident frame `hit_frame` |
| hit_frame | input | IDX_W | Frame index of the hit |
| fill_valid | input | 1 | The frame named by `victim_frame` was just filled |
| free_avail | output | 1 | At least one frame has never been filled |
| victim_frame | output | IDX_W | Frame the next fill will use (a free frame or the eviction victim) |

## Verification
The bench builds the block with the default of three frames. This is the size at which the classic twelve-reference string gives different fault counts and different victims for the two policies, so a policy mix-up or a wrong reorder shows up as a wrong evicted page. Three frames also make the queue short enough that hits on the head, the middle and the tail entry all occur. A colliding hit on the second entry during a fill leaves a different head depending on which notification wins.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_FILL  = 2'd1,
        OP_TOUCH = 2'd2
    } rs_op_e;

endpackage

// File: rtl/rs_match_find.sv
module rs_match_find #(
    parameter int NUM_FRAMES = 3,
    parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    parameter int CNT_W      = $clog2(NUM_FRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] entries [NUM_FRAMES],
    input  logic [CNT_W-1:0] count,
    input  logic [IDX_W-1:0] key,
    output logic             found,
    output logic [IDX_W-1:0] pos
);

    logic [NUM_FRAMES-1:0] match;

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_cmp
        assign match[g] = (CNT_W'(g) < count) && (entries[g] == key);
    end

    always_comb begin
        pos = '0;
        for (int i = 0; i < NUM_FRAMES; i++) begin
            if (match[i]) pos = IDX_W'(i);
        end
    end

    assign found = |match;

    // Each frame index is stored at most once among valid entries (R7).
    assert_unique_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/rs_order_queue.sv
module rs_order_queue
    import rs_pkg::*;
#(
    parameter int NUM_FRAMES = 3,
    parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    parameter int CNT_W      = $clog2(NUM_FRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rs_op_e           op,
    input  logic [IDX_W-1:0] touch_pos,
    output logic [IDX_W-1:0] entries [NUM_FRAMES],
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_FRAMES);

    typedef struct {
        logic [IDX_W-1:0] ent [NUM_FRAMES];
        logic [CNT_W-1:0] cnt;
    } queue_t;

    queue_t st_d, st_q;
    logic [IDX_W-1:0] moved;

    always_comb begin
        st_d  = st_q;
        moved = st_q.ent[touch_pos];
        unique case (op)
            OP_FILL: begin
                if (st_q.cnt < FULL_CNT) begin
                    for (int i = 0; i < NUM_FRAMES; i++) begin
                        if (CNT_W'(i) == st_q.cnt) st_d.ent[i] = IDX_W'(i);
                    end
                    st_d.cnt = st_q.cnt + 1'b1;
                end else begin
                    for (int i = 0; i < NUM_FRAMES - 1; i++) begin
                        st_d.ent[i] = st_q.ent[i+1];
                    end
                    st_d.ent[NUM_FRAMES-1] = st_q.ent[0];
                end
            end
            OP_TOUCH: begin
                for (int i = 0; i < NUM_FRAMES - 1; i++) begin
                    if ((IDX_W'(i) >= touch_pos) && (CNT_W'(i + 1) < st_q.cnt)) begin
                        st_d.ent[i] = st_q.ent[i+1];
                    end
                end
                for (int i = 0; i < NUM_FRAMES; i++) begin
                    if (CNT_W'(i + 1) == st_q.cnt) st_d.ent[i] = moved;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            for (int i = 0; i < NUM_FRAMES; i++) st_q.ent[i] <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign entries = st_q.ent;
    assign count   = st_q.cnt;

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);

    assert_free_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FILL && st_q.cnt < FULL_CNT) |=> st_q.cnt == $past(st_q.cnt) + 1'b1);

    assert_evict_to_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FILL && st_q.cnt == FULL_CNT)
        |=> (st_q.ent[NUM_FRAMES-1] == $past(st_q.ent[0])) && (st_q.cnt == FULL_CNT));

    assert_full_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == FULL_CNT) |=> (st_q.cnt == FULL_CNT));

endmodule

// File: rtl/rs_frame_replacer.sv
module rs_frame_replacer
    import rs_pkg::*;
#(
    parameter int NUM_FRAMES = 3,
    parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             policy_lru,
    input  logic             hit_valid,
    input  logic [IDX_W-1:0] hit_frame,
    input  logic             fill_valid,
    output logic             free_avail,
    output logic [IDX_W-1:0] victim_frame
);

    localparam int               CNT_W    = $clog2(NUM_FRAMES + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_FRAMES);

    logic [IDX_W-1:0] entries [NUM_FRAMES];
    logic [CNT_W-1:0] count;
    logic             found;
    logic [IDX_W-1:0] pos;
    rs_op_e           op;

    rs_match_find #(
        .NUM_FRAMES(NUM_FRAMES),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W)
    ) u_find (
        .clk    (clk),
        .rst_n  (rst_n),
        .entries(entries),
        .count  (count),
        .key    (hit_frame),
        .found  (found),
        .pos    (pos)
    );

    // Fill has priority over a colliding hit (R8); FIFO ignores hits (R6).
    always_comb begin
        if (fill_valid)                             op = OP_FILL;
        else if (hit_valid && policy_lru && found)  op = OP_TOUCH;
        else                                        op = OP_NONE;
    end

    rs_order_queue #(
        .NUM_FRAMES(NUM_FRAMES),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W)
    ) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .touch_pos(pos),
        .entries  (entries),
        .count    (count)
    );

    assign free_avail   = (count < FULL_CNT);
    assign victim_frame = free_avail ? IDX_W'(count) : entries[0];

    assert_fifo_hit_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !fill_valid && !policy_lru)
        |=> $stable(victim_frame) && $stable(free_avail));

    assert_lru_to_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !fill_valid && policy_lru && !free_avail && found)
        |=> entries[NUM_FRAMES-1] == $past(hit_frame));

    assert_fill_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && fill_valid && !free_avail)
        |=> entries[NUM_FRAMES-1] == $past(victim_frame));

    assert_stray_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !fill_valid && !found) |=> $stable(count) && $stable(victim_frame));

endmodule

// File: tb/rs_frame_replacer_tb.sv
module rs_frame_replacer_tb;

    localparam int NF    = 3;
    localparam int IDX_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             policy_lru = 1'b0;
    logic             hit_valid = 1'b0;
    logic [IDX_W-1:0] hit_frame = '0;
    logic             fill_valid = 1'b0;
    logic             free_avail;
    logic [IDX_W-1:0] victim_frame;

    always #4 clk = ~clk;   // 125 MHz

    rs_frame_replacer #(.NUM_FRAMES(NF), .IDX_W(IDX_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .policy_lru  (policy_lru),
        .hit_valid   (hit_valid),
        .hit_frame   (hit_frame),
        .fill_valid  (fill_valid),
        .free_avail  (free_avail),
        .victim_frame(victim_frame)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    int frame_page [NF];
    int loaded;
    int faults;

    // scoreboard: expected fill outcome, -1 in page means "free frame expected"
    int exp_page_q [$];
    int exp_frame_q [$];
    string exp_req_q [$];
    event sample_ev;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // monitor: compares each fill against the queued expectation
    initial begin
        forever begin
            @(sample_ev);
            if (exp_page_q.size() > 0) begin
                int ep, ef;
                string rq;
                ep = exp_page_q.pop_front();
                ef = exp_frame_q.pop_front();
                rq = exp_req_q.pop_front();
                if (ep < 0) begin
                    check(free_avail == 1'b1, {rq, " free flag"}, int'(free_avail), 1);
                    check(int'(victim_frame) == ef, {rq, " free frame"}, int'(victim_frame), ef);
                end else begin
                    check(free_avail == 1'b0, {rq, " full flag"}, int'(free_avail), 0);
                    check(frame_page[victim_frame] == ep, {rq, " evicted page"},
                          frame_page[victim_frame], ep);
                end
            end
        end
    end

    task automatic do_reset(input bit lru);
        @(negedge clk);
        rst_n = 1'b0; policy_lru = lru; hit_valid = 1'b0; fill_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NF; i++) frame_page[i] = -1;
        loaded = 0; faults = 0;
        #2;
        check(free_avail == 1'b1, "R1 free after reset", int'(free_avail), 1);
        check(victim_frame == '0, "R1 victim after reset", int'(victim_frame), 0);
    endtask

    // driver: one page reference; expv = expected evicted page (-1 none)
    task automatic ref_page(input int pg, input bit exp_fault, input int expv);
        int f;
        logic [IDX_W-1:0] vf, v_before;
        f = -1;
        for (int i = 0; i < NF; i++) if (frame_page[i] == pg) f = i;
        check((f < 0) == exp_fault, "R9 fault pattern", int'(f < 0), int'(exp_fault));
        @(negedge clk);
        v_before = victim_frame;
        if (f < 0) begin
            faults++;
            exp_page_q.push_back(loaded < NF ? -1 : expv);
            exp_frame_q.push_back(loaded);
            exp_req_q.push_back(loaded < NF ? "R2" : (policy_lru ? "R7 R9" : "R4 R9"));
            fill_valid = 1'b1;
            #2 -> sample_ev;
            vf = victim_frame;
            @(posedge clk);
            frame_page[vf] = pg;
            if (loaded < NF) loaded++;
            @(negedge clk);
            fill_valid = 1'b0;
        end else begin
            hit_valid = 1'b1;
            hit_frame = IDX_W'(f);
            @(negedge clk);
            hit_valid = 1'b0;
            #2;
            if (!policy_lru)
                check(victim_frame == v_before, "R6 FIFO hit inert",
                      int'(victim_frame), int'(v_before));
        end
    endtask

    int refs   [12] = '{6, 8, 3, 8, 6, 0, 3, 6, 3, 5, 3, 6};
    bit f_fifo [12] = '{1, 1, 1, 0, 0, 1, 0, 1, 0, 1, 1, 0};
    int v_fifo [12] = '{-1, -1, -1, -1, -1, 6, -1, 8, -1, 3, 0, -1};
    bit f_lru  [12] = '{1, 1, 1, 0, 0, 1, 1, 0, 0, 1, 0, 0};
    int v_lru  [12] = '{-1, -1, -1, -1, -1, 3, 8, -1, -1, 0, -1, -1};

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int fr3;
        // FIFO run
        do_reset(1'b0);
        for (int i = 0; i < 12; i++) begin
            ref_page(refs[i], f_fifo[i], v_fifo[i]);
            if (i == 2) check(free_avail == 1'b0, "R3 full after fills", int'(free_avail), 0);
        end
        check(faults == 7, "R9 FIFO fault count", faults, 7);

        // LRU run
        do_reset(1'b1);
        // R10: hit on an unfilled frame is ignored
        ref_page(6, 1'b1, -1);
        @(negedge clk);
        hit_valid = 1'b1; hit_frame = 2'd2;
        @(negedge clk);
        hit_valid = 1'b0;
        #2;
        check(free_avail == 1'b1 && victim_frame == 2'd1, "R10 stray hit",
              int'(victim_frame), 1);
        do_reset(1'b1);
        for (int i = 0; i < 12; i++) ref_page(refs[i], f_lru[i], v_lru[i]);
        check(faults == 6, "R9 LRU fault count", faults, 6);

        // R8: LRU order now 5,3,6; fill and hit on page 3 together
        fr3 = -1;
        for (int i = 0; i < NF; i++) if (frame_page[i] == 3) fr3 = i;
        @(negedge clk);
        check(frame_page[victim_frame] == 5, "R7 LRU head before collision",
              frame_page[victim_frame], 5);
        // R11: outputs unchanged before the edge
        fill_valid = 1'b1; hit_valid = 1'b1; hit_frame = IDX_W'(fr3);
        #2;
        check(frame_page[victim_frame] == 5, "R11 no combinational change",
              frame_page[victim_frame], 5);
        frame_page[victim_frame] = 9;
        @(negedge clk);
        fill_valid = 1'b0; hit_valid = 1'b0;
        #2;
        check(int'(victim_frame) == fr3, "R8 fill wins, R5 new head", int'(victim_frame), fr3);

        // R7 hit on head moves it to tail: next head is page 6
        ref_page(3, 1'b0, -1);
        check(frame_page[victim_frame] == 6, "R7 head after touch",
              frame_page[victim_frame], 6);
        finish_run();
    end

endmodule